// File: doc/BRIEF.md
# Multiplexed CPU Bus Capture Unit

This block observes the bus of an 8-bit processor that presents a 16-bit address as two bytes, one after the other, on an 8-bit address bus. Two timing pulses mark the bus phases. A rising edge of the first pulse marks the high address byte. A rising edge of the second pulse marks the low address byte, together with the data byte and the I/O select code. The unit joins the two bytes into one full address. On the first pulse it also records the processor state code, and in execute cycles the external flag inputs. After every capture it raises a one-cycle valid pulse for the logic downstream.

A source-select input sets who owns the bus. When it is low, the unit samples the processor's pins. When it is high, a local controller owns the bus. The controller writes address and data bytes into the unit, which drives them onto the pins, and it fires its own timing pulses. While the controller owns the bus, the read and write strobes are held at their inactive high level, both timing-pulse pins are held low, and the pin output enable is raised. The data pins are wired in reverse bit order, so the unit reverses each byte on the way in and again on the way out. The state-code pins are wired with their two bits crossed.

Top module: `mxbus_capture`

## Requirements
- R1: While `rst` is high and on the first cycle after it, the captured address, data, select code, state and flags are zero, `cap_valid_o` is low, and `pin_oe_o` is low (external source).
- R2: A rising edge on the active first timing pulse loads the source address byte into `cap_addr_o[15:8]` and leaves `cap_addr_o[7:0]` unchanged. The result appears three clock edges after the pulse goes high: two synchronizer stages, then the capture register.
- R3: A rising edge on the active second timing pulse loads the source address byte into `cap_addr_o[7:0]`, the data byte into `cap_data_o` and `ext_nsel_i` into `cap_nsel_o`. It leaves `cap_addr_o[15:8]` unchanged.
- R4: On a first-pulse capture, `cap_state_o` takes the state pins with their two bits exchanged: `cap_state_o = {ext_sc_i[0], ext_sc_i[1]}`. Raw values 0,1,2,3 therefore decode to 0,2,1,3. The decoded codes are 0 fetch, 1 execute, 2 DMA and 3 interrupt.
- R5: `cap_flag_o` loads `ext_flag_i` on a first-pulse capture only when the decoded state is 1 (execute). Otherwise it keeps its value.
- R6: Data pin bit i carries logical bit 7-i. Captured data and `view_data_o` are the reversed pin byte, and `pin_data_o` is the reversed local data byte.
- R7: With `src_local_i` high, captures use the locally written address and data bytes and the local timing pulses. Pulses on the external timing-pulse pins cause no capture.
- R8: With the local source selected, `pin_oe_o` is 1, `pin_rd_n_o` and `pin_wr_n_o` are 1, `pin_tpa_o` and `pin_tpb_o` are 0, and `pin_ma_o` carries the last local address byte.
- R9: Each rising edge of a timing pulse gives exactly one single-cycle `cap_valid_o`, with `cap_kind_o` bit 1 set for the first pulse and bit 0 set for the second. A held pulse or a falling edge gives no capture, and captured values change only together with `cap_valid_o`.
- R10: `view_ma_o` and `view_data_o` show the pin address and the reversed pin data when the external source is selected, and the last locally written bytes when the local source is selected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| src_local_i | input | 1 | 0 external processor owns bus, 1 local controller |
| ext_ma_i | input | 8 | Multiplexed address pins |
| ext_data_i | input | 8 | Data pins (bit-reversed) |
| ext_nsel_i | input | 3 | I/O select pins |
| ext_sc_i | input | 2 | State-code pins (bits crossed) |
| ext_flag_i | input | 4 | External flag pins |
| ext_tpa_i | input | 1 | First timing pulse from processor (asynchronous) |
| ext_tpb_i | input | 1 | Second timing pulse from processor (asynchronous) |
| loc_ma_we_i | input | 1 | Local address byte write |
| loc_ma_i | input | 8 | Local address byte |
| loc_data_we_i | input | 1 | Local data byte write |
| loc_data_i | input | 8 | Local data byte (logical order) |
| loc_tpa_i | input | 1 | First timing pulse from local controller |
| loc_tpb_i | input | 1 | Second timing pulse from local controller |
| pin_oe_o | output | 1 | Output enable for the driven pins |
| pin_ma_o | output | 8 | Address byte driven onto pins |
| pin_data_o | output | 8 | Data byte driven onto pins (bit-reversed) |
| pin_rd_n_o | output | 1 | Read strobe drive, active low |
| pin_wr_n_o | output | 1 | Write strobe drive, active low |
| pin_tpa_o | output | 1 | First timing-pulse drive |
| pin_tpb_o | output | 1 | Second timing-pulse drive |
| view_ma_o | output | 8 | Current address byte of the selected source |
| view_data_o | output | 8 | Current data byte of the selected source |
| cap_addr_o | output | 16 | Rebuilt address |
| cap_data_o | output | 8 | Captured data byte |
| cap_nsel_o | output | 3 | Captured I/O select |
| cap_state_o | output | 2 | Decoded state code |
| cap_flag_o | output | 4 | Flags captured in execute cycles |
| cap_valid_o | output | 1 | One-cycle capture pulse |
| cap_kind_o | output | 2 | Bit 1 first-pulse capture, bit 0 second-pulse capture |

## Verification
A first-pulse capture followed by a second-pulse capture with different bytes shows whether each half of the address is held while the other half loads. All four raw state-code values are applied, each with a distinct flag pattern. This tells the bit crossing apart from a straight copy, and shows that only the execute code moves the flags. An asymmetric data byte separates a reversed path from a straight one. A long held pulse shows that a level does not capture again. Pulses on the external pins while the local source is selected, followed by a return to the external source, show which source the views and captures follow.

// File: rtl/mxb_pkg.sv
package mxb_pkg;
  typedef enum logic [1:0] {
    ST_FETCH = 2'd0,
    ST_EXEC  = 2'd1,
    ST_DMA   = 2'd2,
    ST_INTR  = 2'd3
  } bus_state_e;

  function automatic bus_state_e decode_state(input logic [1:0] raw);
    return bus_state_e'({raw[0], raw[1]});
  endfunction
endpackage

// File: rtl/mxb_pulse_edge.sv
module mxb_pulse_edge #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pulse_i,
  output logic rise_o
);
  logic [STAGES-1:0] sync_q;
  logic              prev_q;

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) sync_q[0] <= 1'b0;
          else     sync_q[0] <= pulse_i;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) sync_q[s] <= 1'b0;
          else     sync_q[s] <= sync_q[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) prev_q <= 1'b0;
    else     prev_q <= sync_q[STAGES-1];
  end

  assign rise_o = sync_q[STAGES-1] & ~prev_q;
endmodule

// File: rtl/mxb_src_mux.sv
module mxb_src_mux #(
  parameter int BYTE_W = 8
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sel_local_i,
  input  logic [BYTE_W-1:0] pin_ma_i,
  input  logic [BYTE_W-1:0] pin_data_i,
  input  logic              loc_ma_we_i,
  input  logic [BYTE_W-1:0] loc_ma_i,
  input  logic              loc_data_we_i,
  input  logic [BYTE_W-1:0] loc_data_i,
  output logic [BYTE_W-1:0] src_ma_o,
  output logic [BYTE_W-1:0] src_data_o,
  output logic [BYTE_W-1:0] view_ma_o,
  output logic [BYTE_W-1:0] view_data_o,
  output logic              pin_oe_o,
  output logic [BYTE_W-1:0] pin_ma_o,
  output logic [BYTE_W-1:0] pin_data_o,
  output logic              pin_rd_n_o,
  output logic              pin_wr_n_o,
  output logic              pin_tpa_o,
  output logic              pin_tpb_o
);
  logic [BYTE_W-1:0] loc_ma_q;
  logic [BYTE_W-1:0] loc_data_q;
  logic [BYTE_W-1:0] pin_data_logical;
  logic [BYTE_W-1:0] loc_data_wire;

  // Data pins are wired in mirrored order in both directions.
  generate
    for (genvar b = 0; b < BYTE_W; b++) begin : g_rev
      assign pin_data_logical[b] = pin_data_i[BYTE_W-1-b];
      assign loc_data_wire[b]    = loc_data_q[BYTE_W-1-b];
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      loc_ma_q   <= '0;
      loc_data_q <= '0;
    end else begin
      if (loc_ma_we_i)   loc_ma_q   <= loc_ma_i;
      if (loc_data_we_i) loc_data_q <= loc_data_i;
    end
  end

  always_comb begin
    src_ma_o   = sel_local_i ? loc_ma_q   : pin_ma_i;
    src_data_o = sel_local_i ? loc_data_q : pin_data_logical;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      view_ma_o   <= '0;
      view_data_o <= '0;
      pin_oe_o    <= 1'b0;
      pin_ma_o    <= '0;
      pin_data_o  <= '0;
      pin_rd_n_o  <= 1'b1;
      pin_wr_n_o  <= 1'b1;
      pin_tpa_o   <= 1'b0;
      pin_tpb_o   <= 1'b0;
    end else begin
      view_ma_o   <= src_ma_o;
      view_data_o <= src_data_o;
      pin_oe_o    <= sel_local_i;
      pin_ma_o    <= loc_ma_q;
      pin_data_o  <= loc_data_wire;
      pin_rd_n_o  <= 1'b1;
      pin_wr_n_o  <= 1'b1;
      pin_tpa_o   <= 1'b0;
      pin_tpb_o   <= 1'b0;
    end
  end
endmodule

// File: rtl/mxb_capture_regs.sv
module mxb_capture_regs
  import mxb_pkg::*;
#(
  parameter int BYTE_W = 8,
  parameter int NSEL_W = 3,
  parameter int FLAG_W = 4,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              rise_hi_i,
  input  logic              rise_lo_i,
  input  logic [BYTE_W-1:0] src_ma_i,
  input  logic [BYTE_W-1:0] src_data_i,
  input  logic [NSEL_W-1:0] nsel_i,
  input  logic [1:0]        sc_raw_i,
  input  logic [FLAG_W-1:0] flag_i,
  output logic [ADDR_W-1:0] addr_o,
  output logic [BYTE_W-1:0] data_o,
  output logic [NSEL_W-1:0] nsel_o,
  output logic [1:0]        state_o,
  output logic [FLAG_W-1:0] flag_o,
  output logic              valid_o,
  output logic [1:0]        kind_o
);
  bus_state_e state_next;

  always_comb state_next = decode_state(sc_raw_i);

  always_ff @(posedge clk) begin
    if (rst) begin
      addr_o  <= '0;
      data_o  <= '0;
      nsel_o  <= '0;
      state_o <= '0;
      flag_o  <= '0;
      valid_o <= 1'b0;
      kind_o  <= '0;
    end else begin
      valid_o <= rise_hi_i | rise_lo_i;
      kind_o  <= {rise_hi_i, rise_lo_i};
      if (rise_hi_i) begin
        addr_o[ADDR_W-1:BYTE_W] <= src_ma_i;
        state_o                 <= state_next;
        if (state_next == ST_EXEC) flag_o <= flag_i;
      end
      if (rise_lo_i) begin
        addr_o[BYTE_W-1:0] <= src_ma_i;
        data_o             <= src_data_i;
        nsel_o             <= nsel_i;
      end
    end
  end
endmodule

// File: rtl/mxbus_capture.sv
module mxbus_capture #(
  parameter int BYTE_W      = 8,
  parameter int NSEL_W      = 3,
  parameter int FLAG_W      = 4,
  parameter int SYNC_STAGES = 2,
  localparam int ADDR_W     = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              src_local_i,
  input  logic [BYTE_W-1:0] ext_ma_i,
  input  logic [BYTE_W-1:0] ext_data_i,
  input  logic [NSEL_W-1:0] ext_nsel_i,
  input  logic [1:0]        ext_sc_i,
  input  logic [FLAG_W-1:0] ext_flag_i,
  input  logic              ext_tpa_i,
  input  logic              ext_tpb_i,
  input  logic              loc_ma_we_i,
  input  logic [BYTE_W-1:0] loc_ma_i,
  input  logic              loc_data_we_i,
  input  logic [BYTE_W-1:0] loc_data_i,
  input  logic              loc_tpa_i,
  input  logic              loc_tpb_i,
  output logic              pin_oe_o,
  output logic [BYTE_W-1:0] pin_ma_o,
  output logic [BYTE_W-1:0] pin_data_o,
  output logic              pin_rd_n_o,
  output logic              pin_wr_n_o,
  output logic              pin_tpa_o,
  output logic              pin_tpb_o,
  output logic [BYTE_W-1:0] view_ma_o,
  output logic [BYTE_W-1:0] view_data_o,
  output logic [ADDR_W-1:0] cap_addr_o,
  output logic [BYTE_W-1:0] cap_data_o,
  output logic [NSEL_W-1:0] cap_nsel_o,
  output logic [1:0]        cap_state_o,
  output logic [FLAG_W-1:0] cap_flag_o,
  output logic              cap_valid_o,
  output logic [1:0]        cap_kind_o
);
  logic              sel_q;
  logic              tpa_src, tpb_src;
  logic              rise_hi, rise_lo;
  logic [BYTE_W-1:0] src_ma, src_data;

  always_ff @(posedge clk) begin
    if (rst) sel_q <= 1'b0;
    else     sel_q <= src_local_i;
  end

  always_comb begin
    tpa_src = sel_q ? loc_tpa_i : ext_tpa_i;
    tpb_src = sel_q ? loc_tpb_i : ext_tpb_i;
  end

  mxb_pulse_edge #(.STAGES(SYNC_STAGES)) u_edge_hi (
    .clk(clk), .rst(rst), .pulse_i(tpa_src), .rise_o(rise_hi)
  );

  mxb_pulse_edge #(.STAGES(SYNC_STAGES)) u_edge_lo (
    .clk(clk), .rst(rst), .pulse_i(tpb_src), .rise_o(rise_lo)
  );

  mxb_src_mux #(.BYTE_W(BYTE_W)) u_mux (
    .clk(clk), .rst(rst), .sel_local_i(sel_q),
    .pin_ma_i(ext_ma_i), .pin_data_i(ext_data_i),
    .loc_ma_we_i(loc_ma_we_i), .loc_ma_i(loc_ma_i),
    .loc_data_we_i(loc_data_we_i), .loc_data_i(loc_data_i),
    .src_ma_o(src_ma), .src_data_o(src_data),
    .view_ma_o(view_ma_o), .view_data_o(view_data_o),
    .pin_oe_o(pin_oe_o), .pin_ma_o(pin_ma_o), .pin_data_o(pin_data_o),
    .pin_rd_n_o(pin_rd_n_o), .pin_wr_n_o(pin_wr_n_o),
    .pin_tpa_o(pin_tpa_o), .pin_tpb_o(pin_tpb_o)
  );

  mxb_capture_regs #(.BYTE_W(BYTE_W), .NSEL_W(NSEL_W), .FLAG_W(FLAG_W)) u_cap (
    .clk(clk), .rst(rst), .rise_hi_i(rise_hi), .rise_lo_i(rise_lo),
    .src_ma_i(src_ma), .src_data_i(src_data), .nsel_i(ext_nsel_i),
    .sc_raw_i(ext_sc_i), .flag_i(ext_flag_i),
    .addr_o(cap_addr_o), .data_o(cap_data_o), .nsel_o(cap_nsel_o),
    .state_o(cap_state_o), .flag_o(cap_flag_o),
    .valid_o(cap_valid_o), .kind_o(cap_kind_o)
  );
endmodule

// File: rtl/mxbus_capture_chk.sv
module mxbus_capture_chk #(
  parameter int BYTE_W = 8,
  parameter int NSEL_W = 3,
  parameter int FLAG_W = 4,
  localparam int ADDR_W = 2 * BYTE_W
) (
  input logic              clk,
  input logic              rst,
  input logic [1:0]        ext_sc_i,
  input logic              pin_oe_o,
  input logic              pin_rd_n_o,
  input logic              pin_wr_n_o,
  input logic              pin_tpa_o,
  input logic              pin_tpb_o,
  input logic [ADDR_W-1:0] cap_addr_o,
  input logic [BYTE_W-1:0] cap_data_o,
  input logic [NSEL_W-1:0] cap_nsel_o,
  input logic [1:0]        cap_state_o,
  input logic [FLAG_W-1:0] cap_flag_o,
  input logic              cap_valid_o,
  input logic [1:0]        cap_kind_o
);
  AST_RESET_CLEAR: assert property (@(posedge clk)
    rst |=> (cap_addr_o == '0 && cap_data_o == '0 && cap_nsel_o == '0 &&
             cap_state_o == '0 && cap_flag_o == '0 && !cap_valid_o && !pin_oe_o)); // R1

  AST_LOW_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_o && !cap_kind_o[0]) |-> $stable(cap_addr_o[BYTE_W-1:0])); // R2

  AST_HIGH_BYTE_HELD: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_o && !cap_kind_o[1]) |-> $stable(cap_addr_o[ADDR_W-1:BYTE_W])); // R3

  AST_STATE_CROSSED: assert property (@(posedge clk) disable iff (rst)
    (cap_valid_o && cap_kind_o[1]) |-> cap_state_o == {$past(ext_sc_i[0]), $past(ext_sc_i[1])}); // R4

  AST_FLAGS_EXEC_ONLY: assert property (@(posedge clk) disable iff (rst)
    !(cap_valid_o && cap_kind_o[1] && cap_state_o == 2'd1) |-> $stable(cap_flag_o)); // R5

  AST_LOCAL_DRIVE: assert property (@(posedge clk) disable iff (rst)
    pin_oe_o |-> (pin_rd_n_o && pin_wr_n_o && !pin_tpa_o && !pin_tpb_o)); // R8

  AST_CHANGE_WITH_VALID: assert property (@(posedge clk) disable iff (rst)
    !cap_valid_o |-> ($stable(cap_addr_o) && $stable(cap_data_o) && $stable(cap_nsel_o))); // R9

  AST_VALID_KIND: assert property (@(posedge clk) disable iff (rst)
    cap_valid_o == (cap_kind_o != 2'b00)); // R9
endmodule

bind mxbus_capture mxbus_capture_chk #(
  .BYTE_W(BYTE_W), .NSEL_W(NSEL_W), .FLAG_W(FLAG_W)
) u_chk (
  .clk(clk), .rst(rst), .ext_sc_i(ext_sc_i),
  .pin_oe_o(pin_oe_o), .pin_rd_n_o(pin_rd_n_o), .pin_wr_n_o(pin_wr_n_o),
  .pin_tpa_o(pin_tpa_o), .pin_tpb_o(pin_tpb_o),
  .cap_addr_o(cap_addr_o), .cap_data_o(cap_data_o), .cap_nsel_o(cap_nsel_o),
  .cap_state_o(cap_state_o), .cap_flag_o(cap_flag_o),
  .cap_valid_o(cap_valid_o), .cap_kind_o(cap_kind_o)
);

// File: tb/sim_mxbus_capture.sv
module sim_mxbus_capture;
  logic clk = 1'b0;
  logic rst = 1'b1;
  always #2 clk = ~clk;

  logic       src_local_i = 0;
  logic [7:0] ext_ma_i = 0, ext_data_i = 0;
  logic [2:0] ext_nsel_i = 0;
  logic [1:0] ext_sc_i = 0;
  logic [3:0] ext_flag_i = 0;
  logic       ext_tpa_i = 0, ext_tpb_i = 0;
  logic       loc_ma_we_i = 0, loc_data_we_i = 0;
  logic [7:0] loc_ma_i = 0, loc_data_i = 0;
  logic       loc_tpa_i = 0, loc_tpb_i = 0;
  logic       pin_oe_o, pin_rd_n_o, pin_wr_n_o, pin_tpa_o, pin_tpb_o;
  logic [7:0] pin_ma_o, pin_data_o, view_ma_o, view_data_o, cap_data_o;
  logic [15:0] cap_addr_o;
  logic [2:0] cap_nsel_o;
  logic [1:0] cap_state_o, cap_kind_o;
  logic [3:0] cap_flag_o;
  logic       cap_valid_o;

  mxbus_capture u0 (.*);

  int tests = 0, fails = 0, vcnt = 0;
  logic [3:0] exp_flag = 0;

  always @(negedge clk) if (!rst && cap_valid_o) vcnt++;

  function automatic logic [7:0] rev8(input logic [7:0] v);
    logic [7:0] r;
    for (int i = 0; i < 8; i++) r[i] = v[7-i];
    return r;
  endfunction

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    tests++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, got, exp);
    end
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) @(negedge clk);
  endtask

  // One timing pulse: which=1 first pulse, 0 second; loc selects local pulse input.
  task automatic pulse(input bit which, input bit loc, input int hold);
    @(negedge clk);
    if (loc) begin if (which) loc_tpa_i = 1; else loc_tpb_i = 1; end
    else     begin if (which) ext_tpa_i = 1; else ext_tpb_i = 1; end
    idle(hold);
    loc_tpa_i = 0; loc_tpb_i = 0; ext_tpa_i = 0; ext_tpb_i = 0;
    idle(5);
  endtask

  task automatic t_reset();
    chk("R1 addr", cap_addr_o, 0);
    chk("R1 data", cap_data_o, 0);
    chk("R1 state/flag/nsel", {cap_state_o, cap_flag_o, cap_nsel_o}, 0);
    chk("R1 oe/valid", {pin_oe_o, cap_valid_o}, 0);
  endtask

  task automatic t_first_pulse();
    int v0 = vcnt;
    ext_ma_i = 8'hA5; ext_sc_i = 2'd0; ext_flag_i = 4'hF;
    @(negedge clk); ext_tpa_i = 1;
    idle(2);
    chk("R2 not yet after two edges", cap_addr_o, 16'h0000);
    idle(1);
    chk("R2 high byte after three edges", cap_addr_o, 16'hA500);
    chk("R9 kind first pulse", cap_kind_o, 2'b10);
    ext_tpa_i = 0; idle(5);
    chk("R5 flags held in fetch", cap_flag_o, 0);
    chk("R9 one valid", vcnt - v0, 1);
  endtask

  task automatic t_second_pulse();
    ext_ma_i = 8'h3C; ext_data_i = rev8(8'h01); ext_nsel_i = 3'd5;
    pulse(0, 0, 4);
    chk("R3 low byte, high held", cap_addr_o, 16'hA53C);
    chk("R6 data reversed on capture", cap_data_o, 8'h01);
    chk("R3 nsel", cap_nsel_o, 5);
    chk("R10 view data reversed", view_data_o, 8'h01);
    chk("R10 view addr", view_ma_o, 8'h3C);
  endtask

  task automatic t_state_codes();
    for (int raw = 0; raw < 4; raw++) begin
      logic [1:0] r = raw[1:0];
      ext_sc_i = r; ext_flag_i = 4'h9 ^ r; ext_ma_i = 8'h10 + r;
      pulse(1, 0, 4);
      if (r == 2'd2) exp_flag = 4'h9 ^ r;
      chk("R4 state crossed", cap_state_o, {r[0], r[1]});
      chk("R5 flags only in execute", cap_flag_o, exp_flag);
      chk("R2 addr", cap_addr_o, {8'h10 + r, 8'h3C});
    end
  endtask

  task automatic t_long_pulse();
    int v0 = vcnt;
    ext_ma_i = 8'h44;
    @(negedge clk); ext_tpb_i = 1;
    idle(5);
    ext_ma_i = 8'h99; idle(15);
    ext_tpb_i = 0; idle(6);
    chk("R9 held pulse one capture", vcnt - v0, 1);
    chk("R9 no capture on level or fall", cap_addr_o[7:0], 8'h44);
  endtask

  task automatic t_local();
    int v0;
    src_local_i = 1;
    @(negedge clk); loc_ma_we_i = 1; loc_ma_i = 8'h12; loc_data_we_i = 1; loc_data_i = 8'h0F;
    @(negedge clk); loc_ma_we_i = 0; loc_data_we_i = 0;
    idle(3);
    chk("R8 oe", pin_oe_o, 1);
    chk("R8 strobes high, pulses low", {pin_rd_n_o, pin_wr_n_o, pin_tpa_o, pin_tpb_o}, 4'b1100);
    chk("R8 pin addr", pin_ma_o, 8'h12);
    chk("R6 pin data reversed", pin_data_o, 8'hF0);
    chk("R10 local views", {view_ma_o, view_data_o}, 16'h120F);
    v0 = vcnt;
    ext_ma_i = 8'hFF; ext_data_i = 8'hFF; ext_sc_i = 2'd0;
    pulse(1, 0, 4);
    pulse(0, 0, 4);
    chk("R7 external pulses ignored", vcnt - v0, 0);
    chk("R7 addr unchanged", cap_addr_o, 16'h1344);
    ext_nsel_i = 3'd2;
    pulse(1, 1, 4);
    chk("R7 local first pulse", cap_addr_o, 16'h1244);
    pulse(0, 1, 4);
    chk("R7 local second pulse", cap_addr_o, 16'h1212);
    chk("R7 local data", cap_data_o, 8'h0F);
    chk("R7 nsel", cap_nsel_o, 2);
    src_local_i = 0; ext_ma_i = 8'h77; ext_data_i = 8'h01;
    idle(3);
    chk("R10 views follow pins again", {view_ma_o, view_data_o}, 16'h7780);
    chk("R1 oe low in external mode", pin_oe_o, 0);
  endtask

  initial begin
    idle(4); t_reset();
    @(negedge clk); rst = 0;
    @(negedge clk); t_reset();
    t_first_pulse();
    t_second_pulse();
    t_state_codes();
    t_long_pulse();
    t_local();
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    #400000;
    fails++; tests++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule